// File: doc/BRIEF.md
# Debug Exception Cause and Priority Unit

This unit sits beside a processor's execute stage and decides, one instruction at a time, whether that instruction enters debug mode. The pipeline reports five per-instruction events: the instruction counter is about to expire, an instruction-address breakpoint matched, a data-address breakpoint matched (with the number of the comparator that matched), a wide breakpoint instruction, and a short-form breakpoint instruction. The pipeline, the vector fetch and the address comparators are outside this unit and appear only as inputs.

Events other than the counter are masked while the current interrupt level is at or above the configured debug level. When more than one event is eligible, a fixed ranking picks the one to record. A taken event registers a one-hot cause word, saves the PC of the instruction that raised the event, raises the status word to exception mode at the debug level, and pulses a one-cycle strobe together with the level of the vector to fetch. The unit also holds the instruction counter and the low status bits, and the pipeline can write both.

Top module: `dbg_cause_unit`

## Requirements
- R1: A synchronous reset clears `cause`, `epc`, `dbgTake` and `vecLevel` to zero and sets `psLow` to 0x1F.
- R2: A taken event sets exactly one of the cause bits. Bit 0 is counter expiry, bit 1 is the instruction breakpoint, bit 2 is the data breakpoint, bit 3 is the wide breakpoint instruction and bit 4 is the short breakpoint instruction.
- R3: For a data-breakpoint cause, `cause[11:8]` holds `dbreakIdx`. For every other cause these bits are zero.
- R4: When several events are eligible in the same instruction, only the highest-ranked one is recorded. The ranking is counter expiry, then instruction breakpoint, then data breakpoint, then wide breakpoint, then short breakpoint.
- R5: The instruction breakpoint, data breakpoint and both breakpoint instructions are ignored while `psLow[3:0]` is greater than or equal to `DBG_LEVEL`. When they are ignored, `cause`, `epc` and `psLow` do not change and `dbgTake` stays low.
- R6: On a taken event, `psLow` becomes 0x10 OR `DBG_LEVEL`, which is 0x16 for the default level of 6.
- R7: On a taken event, `epc` captures the `instPc` of the instruction that raised it.
- R8: Each counted instruction advances the counter by one. A counted instruction is one with `instValid` high while `psLow[3:0] < cntLevel`. A counted instruction that finds the counter at all ones raises counter expiry and wraps the counter. After a preset of 0xFFFFFFFE, the second counted instruction traps.
- R9: Instructions executed while `psLow[3:0] >= cntLevel` neither advance the counter nor raise counter expiry.
- R10: `dbgTake` is high for exactly the one cycle after the clock edge that samples the causing instruction. In that cycle `vecLevel` equals `DBG_LEVEL`, and it is zero otherwise. Event inputs have no effect when `instValid` is low.
- R11: `psWrEn` loads `psWrData` into `psLow`. A taken event in the same cycle overrides the write.
- R12: `cause` and `epc` keep their values until the next taken event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | An instruction is presented this cycle |
| instPc | input | ADDR_W | Address of the presented instruction |
| ibreakHit | input | 1 | Instruction-address breakpoint match |
| dbreakHit | input | 1 | Data-address breakpoint match |
| dbreakIdx | input | IDX_W | Number of the matching data comparator |
| breakWide | input | 1 | Instruction is the wide breakpoint instruction |
| breakNarrow | input | 1 | Instruction is the short breakpoint instruction |
| cntWrEn | input | 1 | Load the instruction counter |
| cntWrData | input | CNT_W | Counter load value |
| cntLevel | input | LVL_W | Counting happens while the current level is below this value |
| psWrEn | input | 1 | Write the low status bits |
| psWrData | input | LVL_W+1 | Status write value: exception-mode bit above the level field |
| dbgTake | output | 1 | One-cycle debug entry strobe |
| vecLevel | output | LVL_W | Vector level to fetch, valid with the strobe |
| cause | output | 8+IDX_W | Debug cause word |
| epc | output | ADDR_W | Saved PC of the instruction that raised the event |
| psLow | output | LVL_W+1 | Exception-mode bit and current interrupt level |

## Verification
The properties assume that the event inputs have meaning only when `instValid` is high. They also assume that the counter is not reloaded in the cycle after an entry, so a second strobe cannot follow at once. The directed stimulus drives events together with `instValid`, or deliberately without it to show they are dropped, and it changes the counter and status bits only in cycles with no instruction. Each scenario first sets the interrupt level through the status write port so that masking is decided by a known level, and the bench watches the outputs one clock after every instruction.

// File: rtl/dbg_cause_pkg.sv
package dbg_cause_pkg;
  localparam int SRC_N   = 5;
  localparam int IDX_LSB = 8;
  localparam int SRC_ICNT = 0;
  localparam int SRC_IBRK = 1;
  localparam int SRC_DBRK = 2;
  localparam int SRC_BRKW = 3;
  localparam int SRC_BRKN = 4;

  typedef struct packed {
    logic             take;
    logic [SRC_N-1:0] srcSel;
    logic             cntStep;
  } dbgStrobe_t;
endpackage

// File: rtl/dbg_cause_ctrl.sv
module dbg_cause_ctrl
  import dbg_cause_pkg::*;
#(
  parameter int LVL_W     = 4,
  parameter int DBG_LEVEL = 6
) (
  input  logic             instValid,
  input  logic [LVL_W-1:0] levelNow,
  input  logic [LVL_W-1:0] cntLevel,
  input  logic             cntAtMax,
  input  logic             ibreakHit,
  input  logic             dbreakHit,
  input  logic             breakWide,
  input  logic             breakNarrow,
  output dbgStrobe_t       strobe
);
  localparam logic [LVL_W-1:0] DBG_LVL_V = LVL_W'(DBG_LEVEL);

  logic             belowDbg;
  logic             counted;
  logic [SRC_N-1:0] req;
  logic [SRC_N-1:0] sel;

  assign belowDbg = levelNow < DBG_LVL_V;
  assign counted  = instValid && (levelNow < cntLevel);

  always_comb begin
    req           = '0;
    req[SRC_ICNT] = counted && cntAtMax;
    req[SRC_IBRK] = instValid && belowDbg && ibreakHit;
    req[SRC_DBRK] = instValid && belowDbg && dbreakHit;
    req[SRC_BRKW] = instValid && belowDbg && breakWide;
    req[SRC_BRKN] = instValid && belowDbg && breakNarrow;
  end

  // Fixed ranking: lower bit index wins.
  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < SRC_N; i++) begin
      sel[i] = req[i] && !found;
      found  = found || req[i];
    end
  end

  always_comb begin
    strobe.take    = |sel;
    strobe.srcSel  = sel;
    strobe.cntStep = counted;
  end
endmodule

// File: rtl/dbg_cause_dp.sv
module dbg_cause_dp
  import dbg_cause_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 32,
  parameter int LVL_W     = 4,
  parameter int DBG_LEVEL = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dbgStrobe_t            strobe,
  input  logic [ADDR_W-1:0]     instPc,
  input  logic [IDX_W-1:0]      dbreakIdx,
  input  logic                  cntWrEn,
  input  logic [CNT_W-1:0]      cntWrData,
  input  logic                  psWrEn,
  input  logic [LVL_W:0]        psWrData,
  output logic                  cntAtMax,
  output logic                  dbgTake,
  output logic [LVL_W-1:0]      vecLevel,
  output logic [IDX_LSB+IDX_W-1:0] cause,
  output logic [ADDR_W-1:0]     epc,
  output logic [LVL_W:0]        psLow
);
  localparam int CAUSE_W = IDX_LSB + IDX_W;
  localparam logic [LVL_W-1:0] DBG_LVL_V = LVL_W'(DBG_LEVEL);
  localparam logic [LVL_W:0]   PS_ENTRY  = {1'b1, DBG_LVL_V};
  localparam logic [LVL_W:0]   PS_RESET  = '1;

  logic [CNT_W-1:0]   cnt;
  logic [CAUSE_W-1:0] causeNext;

  assign cntAtMax = &cnt;

  always_comb begin
    causeNext = '0;
    causeNext[SRC_N-1:0] = strobe.srcSel;
    if (strobe.srcSel[SRC_DBRK]) causeNext[IDX_LSB +: IDX_W] = dbreakIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause    <= '0;
      epc      <= '0;
      psLow    <= PS_RESET;
      dbgTake  <= 1'b0;
      vecLevel <= '0;
    end else begin
      dbgTake  <= strobe.take;
      vecLevel <= strobe.take ? DBG_LVL_V : '0;
      if (strobe.take) begin
        cause <= causeNext;
        epc   <= instPc;
        psLow <= PS_ENTRY;
      end else if (psWrEn) begin
        psLow <= psWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (cntWrEn)        cnt <= cntWrData;
    else if (strobe.cntStep) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dbg_cause_unit.sv
module dbg_cause_unit
  import dbg_cause_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 32,
  parameter int LVL_W     = 4,
  parameter int DBG_LEVEL = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     instValid,
  input  logic [ADDR_W-1:0]        instPc,
  input  logic                     ibreakHit,
  input  logic                     dbreakHit,
  input  logic [IDX_W-1:0]         dbreakIdx,
  input  logic                     breakWide,
  input  logic                     breakNarrow,
  input  logic                     cntWrEn,
  input  logic [CNT_W-1:0]         cntWrData,
  input  logic [LVL_W-1:0]         cntLevel,
  input  logic                     psWrEn,
  input  logic [LVL_W:0]           psWrData,
  output logic                     dbgTake,
  output logic [LVL_W-1:0]         vecLevel,
  output logic [IDX_LSB+IDX_W-1:0] cause,
  output logic [ADDR_W-1:0]        epc,
  output logic [LVL_W:0]           psLow
);
  dbgStrobe_t strobe;
  logic       cntAtMax;

  dbg_cause_ctrl #(.LVL_W(LVL_W), .DBG_LEVEL(DBG_LEVEL)) u_ctrl (
    .instValid  (instValid),
    .levelNow   (psLow[LVL_W-1:0]),
    .cntLevel   (cntLevel),
    .cntAtMax   (cntAtMax),
    .ibreakHit  (ibreakHit),
    .dbreakHit  (dbreakHit),
    .breakWide  (breakWide),
    .breakNarrow(breakNarrow),
    .strobe     (strobe)
  );

  dbg_cause_dp #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .LVL_W(LVL_W), .DBG_LEVEL(DBG_LEVEL)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .instPc   (instPc),
    .dbreakIdx(dbreakIdx),
    .cntWrEn  (cntWrEn),
    .cntWrData(cntWrData),
    .psWrEn   (psWrEn),
    .psWrData (psWrData),
    .cntAtMax (cntAtMax),
    .dbgTake  (dbgTake),
    .vecLevel (vecLevel),
    .cause    (cause),
    .epc      (epc),
    .psLow    (psLow)
  );
endmodule

// File: rtl/dbg_cause_unit_chk.sv
module dbg_cause_unit_chk #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 4,
  parameter int LVL_W     = 4,
  parameter int DBG_LEVEL = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               instValid,
  input logic [ADDR_W-1:0]  instPc,
  input logic               ibreakHit,
  input logic               dbgTake,
  input logic [LVL_W-1:0]   vecLevel,
  input logic [8+IDX_W-1:0] cause,
  input logic [ADDR_W-1:0]  epc,
  input logic [LVL_W:0]     psLow
);
  localparam logic [LVL_W-1:0] DBG_LVL_V = LVL_W'(DBG_LEVEL);

  // R2
  onehot_cause_chk: assert property (@(posedge clk) disable iff (rst)
    dbgTake |-> $countones(cause[4:0]) == 1);

  // R3
  idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (dbgTake && !cause[2]) |-> cause[8 +: IDX_W] == '0);

  // R4
  ibrk_rank_chk: assert property (@(posedge clk) disable iff (rst)
    (dbgTake && $past(instValid && ibreakHit)) |-> (cause[1] || cause[0]));

  // R5
  level_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (dbgTake && (|cause[4:1])) |-> $past(psLow[LVL_W-1:0]) < DBG_LVL_V);

  // R6
  ps_entry_chk: assert property (@(posedge clk) disable iff (rst)
    dbgTake |-> psLow == {1'b1, DBG_LVL_V});

  // R7
  epc_capture_chk: assert property (@(posedge clk) disable iff (rst)
    dbgTake |-> epc == $past(instPc));

  // R10
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(instValid) |-> !dbgTake);

  // R10
  vec_level_chk: assert property (@(posedge clk) disable iff (rst)
    dbgTake |-> vecLevel == DBG_LVL_V);

  // R12
  cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dbgTake |-> ($stable(cause) && $stable(epc)));
endmodule

bind dbg_cause_unit dbg_cause_unit_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LVL_W(LVL_W), .DBG_LEVEL(DBG_LEVEL)
) u_chk (
  .clk(clk), .rst(rst), .instValid(instValid), .instPc(instPc),
  .ibreakHit(ibreakHit), .dbgTake(dbgTake), .vecLevel(vecLevel),
  .cause(cause), .epc(epc), .psLow(psLow)
);

// File: tb/dbg_cause_unit_bench.sv
module dbg_cause_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        instValid;
  logic [31:0] instPc;
  logic        ibreakHit, dbreakHit, breakWide, breakNarrow;
  logic [3:0]  dbreakIdx;
  logic        cntWrEn;
  logic [31:0] cntWrData;
  logic [3:0]  cntLevel;
  logic        psWrEn;
  logic [4:0]  psWrData;
  logic        dbgTake;
  logic [3:0]  vecLevel;
  logic [11:0] cause;
  logic [31:0] epc;
  logic [4:0]  psLow;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dbg_cause_unit u_dbg_cause_unit (
    .clk(clk), .rst(rst), .instValid(instValid), .instPc(instPc),
    .ibreakHit(ibreakHit), .dbreakHit(dbreakHit), .dbreakIdx(dbreakIdx),
    .breakWide(breakWide), .breakNarrow(breakNarrow),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .cntLevel(cntLevel),
    .psWrEn(psWrEn), .psWrData(psWrData),
    .dbgTake(dbgTake), .vecLevel(vecLevel), .cause(cause),
    .epc(epc), .psLow(psLow)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    instValid = 0; instPc = 0; ibreakHit = 0; dbreakHit = 0; dbreakIdx = 0;
    breakWide = 0; breakNarrow = 0; cntWrEn = 0; cntWrData = 0;
    psWrEn = 0; psWrData = 0;
  endtask

  // Present one instruction at a falling edge; outputs are valid at the next falling edge.
  task automatic issue(input logic [31:0] pc, input bit ib, input bit db,
                       input bit bw, input bit bn, input logic [3:0] idx,
                       input bit valid);
    instValid = valid; instPc = pc; ibreakHit = ib; dbreakHit = db;
    breakWide = bw; breakNarrow = bn; dbreakIdx = idx;
    @(negedge clk);
    clearIn();
  endtask

  task automatic setPs(input logic [4:0] v);
    psWrEn = 1; psWrData = v;
    @(negedge clk);
    psWrEn = 0; psWrData = 0;
    chk("R11", "status write", {27'd0, psLow}, {27'd0, v});
  endtask

  task automatic setCnt(input logic [31:0] v);
    cntWrEn = 1; cntWrData = v;
    @(negedge clk);
    cntWrEn = 0; cntWrData = 0;
  endtask

  task automatic expectTake(input string req, input logic [11:0] c, input logic [31:0] pc);
    chk(req, "strobe", {31'd0, dbgTake}, 32'd1);
    chk(req, "cause", {20'd0, cause}, {20'd0, c});
    chk("R7", "epc", epc, pc);
    chk("R6", "status", {27'd0, psLow}, 32'h16);
    chk("R10", "vector level", {28'd0, vecLevel}, 32'd6);
  endtask

  task automatic expectNone(input string req, input logic [11:0] c, input logic [31:0] pc,
                            input logic [4:0] ps);
    chk(req, "no strobe", {31'd0, dbgTake}, 32'd0);
    chk(req, "cause unchanged", {20'd0, cause}, {20'd0, c});
    chk(req, "epc unchanged", epc, pc);
    chk(req, "status unchanged", {27'd0, psLow}, {27'd0, ps});
  endtask

  task automatic t_reset();
    chk("R1", "cause", {20'd0, cause}, 32'd0);
    chk("R1", "epc", epc, 32'd0);
    chk("R1", "status", {27'd0, psLow}, 32'h1F);
    chk("R1", "strobe", {31'd0, dbgTake}, 32'd0);
    chk("R1", "vector level", {28'd0, vecLevel}, 32'd0);
  endtask

  task automatic t_masked();
    setPs(5'h06);
    issue(32'h40, 0, 0, 1, 0, 0, 1);
    expectNone("R5", 12'h0, 32'h0, 5'h06);
    setPs(5'h07);
    issue(32'h44, 1, 0, 0, 0, 0, 1);
    expectNone("R5", 12'h0, 32'h0, 5'h07);
    issue(32'h48, 0, 1, 0, 1, 4'h2, 1);
    expectNone("R5", 12'h0, 32'h0, 5'h07);
    setPs(5'h00);
    issue(32'h4C, 1, 1, 1, 1, 4'h1, 0);
    expectNone("R10", 12'h0, 32'h0, 5'h00);
  endtask

  task automatic t_wide();
    setPs(5'h05);
    issue(32'h100, 0, 0, 1, 0, 0, 1);
    expectTake("R2", 12'h008, 32'h100);
    @(negedge clk);
    chk("R10", "strobe drops", {31'd0, dbgTake}, 32'd0);
    chk("R10", "vector level idle", {28'd0, vecLevel}, 32'd0);
    chk("R12", "cause holds", {20'd0, cause}, 32'h008);
    issue(32'h200, 0, 0, 0, 1, 0, 1);
    expectNone("R5", 12'h008, 32'h100, 5'h16);
  endtask

  task automatic t_single();
    setPs(5'h00);
    issue(32'h204, 0, 0, 0, 1, 0, 1);
    expectTake("R2", 12'h010, 32'h204);
    setPs(5'h03);
    issue(32'h208, 1, 0, 0, 0, 0, 1);
    expectTake("R2", 12'h002, 32'h208);
    setPs(5'h00);
    issue(32'h20C, 0, 1, 0, 0, 4'h3, 1);
    expectTake("R3", 12'h304, 32'h20C);
    setPs(5'h05);
    issue(32'h210, 0, 1, 0, 0, 4'hF, 1);
    expectTake("R3", 12'hF04, 32'h210);
  endtask

  task automatic t_priority();
    setPs(5'h00);
    issue(32'h300, 1, 0, 1, 0, 0, 1);
    expectTake("R4", 12'h002, 32'h300);
    setPs(5'h00);
    issue(32'h304, 0, 1, 1, 1, 4'h5, 1);
    expectTake("R4", 12'h504, 32'h304);
    setPs(5'h00);
    issue(32'h308, 0, 0, 1, 1, 0, 1);
    expectTake("R4", 12'h008, 32'h308);
    cntLevel = 4'd2;
    setCnt(32'hFFFF_FFFF);
    setPs(5'h00);
    issue(32'h30C, 1, 1, 0, 0, 4'h7, 1);
    expectTake("R4", 12'h001, 32'h30C);
    cntLevel = 4'd0;
  endtask

  task automatic t_icount();
    cntLevel = 4'd1;
    setPs(5'h00);
    setCnt(32'hFFFF_FFFE);
    issue(32'h400, 0, 0, 0, 0, 0, 1);
    expectNone("R8", 12'h001, 32'h30C, 5'h00);
    issue(32'h404, 0, 0, 0, 0, 0, 1);
    expectTake("R8", 12'h001, 32'h404);
    cntLevel = 4'd0;
  endtask

  task automatic t_icount_gate();
    cntLevel = 4'd1;
    setPs(5'h02);
    setCnt(32'hFFFF_FFFF);
    for (int i = 0; i < 3; i++) begin
      issue(32'h500 + 32'(i * 4), 0, 0, 0, 0, 0, 1);
      expectNone("R9", 12'h001, 32'h404, 5'h02);
    end
    setPs(5'h00);
    issue(32'h510, 0, 0, 0, 0, 0, 1);
    expectTake("R9", 12'h001, 32'h510);
    cntLevel = 4'd0;
  endtask

  task automatic t_ps_conflict();
    setPs(5'h00);
    psWrEn = 1; psWrData = 5'h03;
    issue(32'h600, 0, 0, 1, 0, 0, 1);
    chk("R11", "entry overrides write", {27'd0, psLow}, 32'h16);
    chk("R11", "cause", {20'd0, cause}, 32'h008);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clearIn();
    cntLevel = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_masked();
    t_wide();
    t_single();
    t_priority();
    t_icount();
    t_icount_gate();
    t_ps_conflict();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule